// File: doc/BRIEF.md
# Self-Healing Modified One-Hot Ring Sequencer

This block is a circular sequencer of eight states held in seven flip-flops. The home state is the all-zero vector. Every other state has exactly one bit set. Each advance moves that single bit one place toward the top of the register. When the top bit leaves, the ring returns home.

The ring is built to ride through transient upsets without a global reset. When the vector is all zero, a NOR of the state bits feeds a one into the bottom stage on the next advance, so a lost token is put back on its own. A vector that holds several ones is not forced back to a legal code. It keeps shifting, and the extra ones fall off the top one at a time.

Two health flags report whether the vector is empty or holds more than one set bit. A set of decoded strobes names the current state, and all strobes are held low while the vector is multi-hot. A fault-injection mask lets a test flip chosen state bits in any cycle.

Top module: `mohr_ring`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state vector becomes all zero, whatever `adv_i` and `flip_i` are. After such an edge, `strobe_o[0]` is 1 and every other strobe is 0.
- R2: From the all-zero vector, an advance with no injected flip loads `0000001`. This is state 1.
- R3: From a vector whose only set bit is bit k, with k below 6, an advance with no injected flip gives a vector whose only set bit is bit k+1. This is state k+2.
- R4: From the vector with only bit 6 set, an advance with no injected flip returns the ring to the all-zero vector.
- R5: With `adv_i` low and `flip_i` zero, the state vector holds its value.
- R6: `zero_o` is 1 exactly when all seven state bits are 0.
- R7: `multi_o` is 1 exactly when two or more state bits are 1.
- R8: When `multi_o` is 0, `strobe_o` is one-hot. Bit 0 marks the all-zero vector, and bit k+1 marks the vector with only bit k set. When `multi_o` is 1, all strobes are 0.
- R9: A multi-hot vector is never corrected in one step. On an advance every bit moves up one place, bit 6 is dropped, and a 0 enters bit 0.
- R10: At each rising edge outside reset, the new state is the value R2 to R5 and R9 give, XORed bit by bit with `flip_i` (bit k of the mask flips bit k of the state).
- R11: From any seven-bit vector, with no further flips, the state is legal (at most one bit set) after at most 8 advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_i | input | 1 | Advance enable |
| flip_i | input | 7 | Fault-injection mask; each set bit inverts that state bit at the edge |
| state_o | output | 7 | Current state vector |
| strobe_o | output | 8 | Decoded state strobes, one per state |
| zero_o | output | 1 | All state bits are zero |
| multi_o | output | 1 | Two or more state bits are set |

## Verification
The hardest situation to reach is a multi-hot vector, and above all one that is being shifted while another flip lands. In normal operation the ring never holds more than one set bit.

The stimulus uses the injection mask to place a second one beside the token, and in one step it flips a bit in the same edge as an advance. It then checks, one advance at a time, that the extra ones shift out unchanged while the strobes stay dark.

Separate directed runs load dense patterns, including all ones, and count advances until the vector is legal again.

// File: rtl/mohr_pkg.sv
// Package: shared constants and types of the modified one-hot ring.
// Assumes: the state count is at least 3, so the state vector is at least two bits wide.
package mohr_pkg;
    localparam int unsigned MOHR_STATES_DFLT = 8;

    typedef struct packed {
        logic empty;   // no bit set
        logic crowded; // two or more bits set
    } mohr_health_t;
endpackage

// File: rtl/mohr_advance.sv
// mohr_advance: next-state logic of the ring.
// An advance shifts the vector up one place; an all-zero vector reinjects a one
// at the bottom. The injection mask is XORed onto the result.
// Assumes: W >= 2.
module mohr_advance #(
    parameter int unsigned W = 7
) (
    input  logic [W-1:0] cur_i,
    input  logic         adv_i,
    input  logic [W-1:0] flip_i,
    output logic [W-1:0] nxt_o
);
    logic         refill;
    logic [W-1:0] stepped;

    // Pick the advanced or held vector, then apply injected flips.
    always_comb begin
        refill  = ~|cur_i;
        stepped = adv_i ? {cur_i[W-2:0], refill} : cur_i;
        nxt_o   = stepped ^ flip_i;
    end
endmodule

// File: rtl/mohr_health.sv
// mohr_health: classifies the state vector as empty, single or multi-hot.
// Assumes: purely combinational; the consumer registers nothing from it.
module mohr_health #(
    parameter int unsigned W = 7
) (
    input  logic [W-1:0]          vec_i,
    output mohr_pkg::mohr_health_t hl_o
);
    // Empty test, and a multi-hot test that clears the lowest set bit.
    always_comb begin
        hl_o.empty   = (vec_i == '0);
        hl_o.crowded = |(vec_i & (vec_i - W'(1)));
    end
endmodule

// File: rtl/mohr_decode.sv
// mohr_decode: turns the state vector into one strobe per state.
// Assumes: the health input comes from the same vector; a crowded vector silences every strobe.
module mohr_decode #(
    parameter int unsigned N = 8,
    localparam int unsigned W = N - 1
) (
    input  logic [W-1:0]           vec_i,
    input  mohr_pkg::mohr_health_t hl_i,
    output logic [N-1:0]           strobe_o
);
    // Home strobe comes from the empty flag.
    always_comb strobe_o[0] = hl_i.empty & ~hl_i.crowded;

    genvar g;
    generate
        for (g = 1; g < N; g++) begin : g_stb
            // Each later strobe follows one state bit, gated by the crowded flag.
            always_comb strobe_o[g] = vec_i[g-1] & ~hl_i.crowded;
        end
    endgenerate
endmodule

// File: rtl/mohr_ring.sv
// mohr_ring: eight-state (by default) modified one-hot ring with lockup recovery.
// The home state is all zero. A NOR refill restores a lost token, and extra ones
// shift out on their own. flip_i exists only for fault injection.
// Assumes: synchronous active-low reset; NUM_STATES >= 3.
module mohr_ring #(
    parameter int unsigned NUM_STATES = mohr_pkg::MOHR_STATES_DFLT,
    localparam int unsigned W = NUM_STATES - 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adv_i,
    input  logic [W-1:0]          flip_i,
    output logic [W-1:0]          state_o,
    output logic [NUM_STATES-1:0] strobe_o,
    output logic                  zero_o,
    output logic                  multi_o
);
    logic [W-1:0]           q;
    logic [W-1:0]           q_nxt;
    mohr_pkg::mohr_health_t hl;

    mohr_advance #(.W(W)) u_adv (
        .cur_i (q),
        .adv_i (adv_i),
        .flip_i(flip_i),
        .nxt_o (q_nxt)
    );

    mohr_health #(.W(W)) u_hl (
        .vec_i(q),
        .hl_o (hl)
    );

    mohr_decode #(.N(NUM_STATES)) u_dec (
        .vec_i   (q),
        .hl_i    (hl),
        .strobe_o(strobe_o)
    );

    // State register, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

    // Drive the outputs.
    always_comb begin
        state_o = q;
        zero_o  = hl.empty;
        multi_o = hl.crowded;
    end

    // R2: an empty ring refills its bottom stage.
    a_r2_refill: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && zero_o && flip_i == '0) |=> (state_o == W'(1)));

    // R4: the top bit wraps the ring back home.
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && state_o == (W'(1) << (W-1)) && flip_i == '0) |=> zero_o);

    // R5: with no advance and no flip, the state holds.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && flip_i == '0) |=> $stable(state_o));

    // R8: at most one strobe is active.
    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe_o));

    // R8: a crowded vector keeps every strobe low.
    a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
        multi_o |-> (strobe_o == '0));

    // R9: a multi-hot vector is shifted, not corrected.
    a_r9_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && multi_o && flip_i == '0) |=> (state_o == {$past(state_o[W-2:0]), 1'b0}));

    // R6, R7: the two flags are never set together.
    a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(zero_o && multi_o));
endmodule

// File: tb/sim_mohr_ring.sv
module sim_mohr_ring;
    localparam int CLK_P = 10;
    localparam int N     = 8;
    localparam int W     = N - 1;
    localparam int NV    = 20;

    // Vector table: advance, flip mask, expected state after the edge.
    localparam logic       T_ADV  [NV] = '{1,1,0,1,1,1,1,1,1,0,
                                           1,0,1,0,1,1,1,1,0,1};
    localparam logic [6:0] T_FLIP [NV] = '{7'h00,7'h00,7'h00,7'h00,7'h00,
                                           7'h00,7'h00,7'h00,7'h00,7'h04,
                                           7'h00,7'h08,7'h00,7'h10,7'h00,
                                           7'h00,7'h00,7'h01,7'h00,7'h00};
    localparam logic [6:0] T_EXP  [NV] = '{7'h01,7'h02,7'h02,7'h04,7'h08,
                                           7'h10,7'h20,7'h40,7'h00,7'h04,
                                           7'h08,7'h00,7'h01,7'h11,7'h22,
                                           7'h44,7'h08,7'h11,7'h11,7'h22};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         adv = 1'b0;
    logic [W-1:0] flip = '0;
    logic [W-1:0] state;
    logic [N-1:0] strobe;
    logic         zero, multi;
    int           checks = 0;
    int           errors = 0;

    always #(CLK_P/2) clk = ~clk;

    mohr_ring #(.NUM_STATES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .flip_i(flip),
        .state_o(state), .strobe_o(strobe), .zero_o(zero), .multi_o(multi)
    );

    function automatic int ones(input logic [W-1:0] v);
        int c = 0;
        for (int i = 0; i < W; i++) c += int'(v[i]);
        return c;
    endfunction

    // Strobe pattern the requirements give for a vector.
    function automatic logic [N-1:0] exp_strobe(input logic [W-1:0] v);
        logic [N-1:0] s = '0;
        if (ones(v) == 0) s[0] = 1'b1;
        else if (ones(v) == 1)
            for (int i = 0; i < W; i++) if (v[i]) s[i+1] = 1'b1;
        return s;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Checks the flags and strobes against the current state vector (R6, R7, R8).
    task automatic chk_outputs(input logic [W-1:0] v);
        chk("R6 zero flag", 32'(zero), 32'(ones(v) == 0));
        chk("R7 multi flag", 32'(multi), 32'(ones(v) >= 2));
        chk("R8 strobes", 32'(strobe), 32'(exp_strobe(v)));
    endtask

    // Drives one cycle of inputs, then samples after the edge.
    task automatic step(input logic a, input logic [W-1:0] f);
        @(negedge clk);
        adv  = a;
        flip = f;
        @(negedge clk);
        adv  = 1'b0;
        flip = '0;
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, with advance and flips active during reset.
        adv = 1'b1;
        flip = '1;
        repeat (3) @(negedge clk);
        chk("R1 reset state", 32'(state), 32'h0);
        chk("R1 reset strobe", 32'(strobe), 32'h1);
        adv = 1'b0;
        flip = '0;
        rst_n = 1'b1;

        // Table walk: R2, R3, R4, R5, R9 and R10.
        for (int i = 0; i < NV; i++) begin
            step(T_ADV[i], T_FLIP[i]);
            chk($sformatf("R2/R3/R4/R5/R9/R10 vector %0d", i), 32'(state), 32'(T_EXP[i]));
            chk_outputs(state);
        end

        // R1: reset taken mid-run from a multi-hot state.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset from multi", 32'(state), 32'h0);
        rst_n = 1'b1;

        // R11: dense patterns recover within 8 advances.
        for (int p = 0; p < 5; p++) begin
            logic [W-1:0] pat;
            int           n;
            case (p)
                0: pat = 7'h7F;
                1: pat = 7'h03;
                2: pat = 7'h55;
                3: pat = 7'h41;
                default: pat = 7'h2A;
            endcase
            @(negedge clk);
            rst_n = 1'b0;
            @(negedge clk);
            rst_n = 1'b1;
            step(1'b0, pat);
            chk("R10 pattern loaded", 32'(state), 32'(pat));
            n = 0;
            while (ones(state) > 1 && n < 9) begin
                step(1'b1, '0);
                n++;
            end
            chk($sformatf("R11 legal after %0d advances", n), 32'(n <= 8), 32'h1);
            chk_outputs(state);
        end

        // R4: the wrap from bit 6 alone.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 7'h40);
        step(1'b1, '0);
        chk("R4 wrap home", 32'(state), 32'h0);
        chk_outputs(state);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule